// File: doc/BRIEF.md
# Serial-Output Successive-Approximation Converter Controller

This block is the digital core of an 8-bit converter that reports its results over a three-wire serial link. An external host drives an active-low select line and its own shift clock. Neither signal is related to the block's internal system clock. While select is low, the block drives the stored result onto a serial data pin, most significant bit first. It moves one bit along on each falling edge of the host clock.

The eighth falling edge of an access ends the tracking phase and starts a conversion. The conversion runs for a fixed number of system-clock cycles. During it a successive-approximation sequencer drives a trial code to an external DAC and reads back a one-bit comparator decision, settling one bit at a time. The settled code becomes the result that the next access shifts out. The analog sample-and-hold and the comparator are outside the block. A comparator input pin and a DAC code output pin stand in for them. The data pin comes with an enable that controls an external three-state pad.

Top module: `sadc_ctrl`

## Requirements
- R1: `sdo_oe_o` is 0 while `cs_ni` is high (deselected) and after reset.
- R2: On a falling edge of `cs_ni`, `sdo_oe_o` goes to 1 and `sdo_o` shows bit 7 (the MSB) of the stored result, with no I/O clock edge needed.
- R3: Each of the first seven falling edges of `ioclk_i` in an access moves `sdo_o` to the next lower bit, ending at bit 0. Rising edges of `ioclk_i` do not change `sdo_o`.
- R4: The eighth falling edge of `ioclk_i` in an access starts a conversion. `hold_o` (1 = hold, 0 = track) then stays at 1 for exactly 36 system-clock cycles.
- R5: An access shifts out the result of the conversion started by the previous access. The first access after reset shifts out 0x00.
- R6: Each conversion opens with the trial code 0x80 on `dac_code_o`. One bit is decided every 4 system clocks, from MSB to LSB. `cmp_i` = 1 means the input is at or above the trial code, and the bit under trial is then kept; otherwise it is cleared. The final code equals the input level. `dac_code_o` is 0x00 after reset.
- R7: The stored result changes only in the last cycle of a conversion.
- R8: If `cs_ni` rises before the eighth falling edge, no conversion starts and the edge count is cleared. The next access starts again from the MSB of the same stored result.
- R9: `ioclk_i` edges that arrive during a conversion neither restart it nor change its length or its result.
- R10: Falling edges after the eighth within the same access start no further conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running internal system clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_ni | input | 1 | Active-low select from the host, asynchronous |
| ioclk_i | input | 1 | Host shift clock, asynchronous |
| cmp_i | input | 1 | Comparator decision: 1 when input >= DAC trial code |
| sdo_o | output | 1 | Serial result bit |
| sdo_oe_o | output | 1 | Enable for the external three-state data pad |
| dac_code_o | output | 8 | Trial code for the external DAC |
| hold_o | output | 1 | Sample/hold control and busy flag, 1 = hold/converting |

## Verification
Every cycle, the assertions check these properties: a new access presents the MSB of the stored result as soon as the pad is enabled; the edge count never passes eight and is cleared while deselected; each conversion opens at mid-scale with a one-hot bit under trial; the stored result moves only as a conversion closes; and a start request during a conversion neither restarts it nor stalls its timer. Only the bench scenarios show the exact 36-cycle hold length, the value from the previous access appearing in the next one, the final code matching the input level at the scale extremes, and aborted or over-clocked accesses leaving the conversion count unchanged.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int unsigned RES_W    = 8;
  localparam int unsigned CONV_CYC = 36;
  localparam int unsigned SYNC_N   = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } conv_st_e;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) ff_q[g] <= RST_VAL;
          else         ff_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) ff_q[g] <= RST_VAL;
          else         ff_q[g] <= ff_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/sadc_shift.sv
module sadc_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_s_i,
  input  logic         sck_s_i,
  input  logic [W-1:0] result_i,
  output logic         sdo_o,
  output logic         sdo_oe_o,
  output logic         start_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

  logic             cs_d_q, sck_d_q;
  logic [W-1:0]     sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cs_fall, sck_fall;

  assign cs_fall  = cs_d_q & ~cs_s_i;
  assign sck_fall = sck_d_q & ~sck_s_i & ~cs_s_i;

  always_comb begin
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    start_o = 1'b0;
    if (cs_s_i) begin
      cnt_d = '0;
    end else if (cs_fall) begin
      sh_d  = result_i;
      cnt_d = '0;
    end else if (sck_fall && (cnt_q != CNT_FULL)) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_LAST) start_o = 1'b1;
      else                   sh_d    = {sh_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d_q  <= 1'b1;
      sck_d_q <= 1'b0;
      sh_q    <= '0;
      cnt_q   <= '0;
    end else begin
      cs_d_q  <= cs_s_i;
      sck_d_q <= sck_s_i;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
    end
  end

  assign sdo_o    = sh_q[W-1];
  assign sdo_oe_o = ~cs_d_q;

  // R2: pad enable rises with the stored MSB already in place
  p_msb_on_select_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> sdo_o == $past(result_i[W-1]));
  // R10: edge count saturates at W
  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  // R8: deselect clears the edge count
  p_desel_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> cnt_q == '0);
endmodule

// File: rtl/sadc_sar.sv
module sadc_sar
  import sadc_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned CONV = 36
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         cmp_i,
  output logic [W-1:0] dac_o,
  output logic [W-1:0] result_o,
  output logic         busy_o
);
  localparam int unsigned STEP = CONV / W;
  localparam int unsigned TW   = $clog2(CONV);
  localparam logic [TW-1:0] T_LAST = TW'(CONV - 1);
  localparam logic [TW-1:0] T_STEP = TW'(STEP);
  localparam logic [TW-1:0] T_DEC  = TW'(STEP - 1);
  localparam logic [W-1:0]  MID    = {1'b1, {(W-1){1'b0}}};

  conv_st_e      st_q, st_d;
  logic [TW-1:0] t_q, t_d;
  logic [W-1:0]  trial_q, trial_d, mask_q, mask_d, res_q, res_d;
  logic          decide;

  assign decide = (mask_q != '0) && ((t_q % T_STEP) == T_DEC);

  always_comb begin
    st_d    = st_q;
    t_d     = t_q;
    trial_d = trial_q;
    mask_d  = mask_q;
    res_d   = res_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d    = ST_CONV;
          t_d     = '0;
          trial_d = MID;
          mask_d  = MID;
        end
      end
      ST_CONV: begin
        t_d = t_q + TW'(1);
        if (decide) begin
          trial_d = (cmp_i ? trial_q : (trial_q & ~mask_q)) | (mask_q >> 1);
          mask_d  = mask_q >> 1;
        end
        if (t_q == T_LAST) begin
          st_d  = ST_IDLE;
          res_d = trial_d;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      t_q     <= '0;
      trial_q <= '0;
      mask_q  <= '0;
      res_q   <= '0;
    end else begin
      st_q    <= st_d;
      t_q     <= t_d;
      trial_q <= trial_d;
      mask_q  <= mask_d;
      res_q   <= res_d;
    end
  end

  assign busy_o   = (st_q == ST_CONV);
  assign dac_o    = trial_q;
  assign result_o = res_q;

  // R6: every conversion opens at mid-scale
  p_first_trial_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> dac_o == MID);
  // R6: at most one bit under trial
  p_mask_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mask_q));
  // R7: result only moves as a conversion closes
  p_result_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(busy_o) |-> $stable(result_o));
  // R9: a start request during a conversion does not restart the timer
  p_no_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && (t_q != T_LAST)) |=> busy_o && (t_q == $past(t_q) + TW'(1)));
endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int unsigned RES_W_P    = RES_W,
  parameter int unsigned CONV_CYC_P = CONV_CYC,
  parameter int unsigned SYNC_N_P   = SYNC_N
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               ioclk_i,
  input  logic               cmp_i,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  output logic [RES_W_P-1:0] dac_code_o,
  output logic               hold_o
);
  logic               rst_n_s, cs_s, sck_s, start;
  logic [RES_W_P-1:0] result;

  sadc_sync #(.STAGES(SYNC_N_P), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(rst_n_s));

  sadc_sync #(.STAGES(SYNC_N_P), .RST_VAL(1'b1)) u_cs_sync (
    .clk_i(clk_i), .rst_ni(rst_n_s), .d_i(cs_ni), .q_o(cs_s));

  sadc_sync #(.STAGES(SYNC_N_P), .RST_VAL(1'b0)) u_sck_sync (
    .clk_i(clk_i), .rst_ni(rst_n_s), .d_i(ioclk_i), .q_o(sck_s));

  sadc_shift #(.W(RES_W_P)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .cs_s_i   (cs_s),
    .sck_s_i  (sck_s),
    .result_i (result),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o),
    .start_o  (start)
  );

  sadc_sar #(.W(RES_W_P), .CONV(CONV_CYC_P)) u_sar (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .start_i  (start),
    .cmp_i    (cmp_i),
    .dac_o    (dac_code_o),
    .result_o (result),
    .busy_o   (hold_o)
  );

  // R1: pad disabled while deselected and settled
  p_desel_off_r1: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (cs_s && $past(cs_s)) |-> !sdo_oe_o);
endmodule

// File: tb/sadc_ctrl_tb.sv
module sadc_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       ioclk = 1'b0;
  logic [7:0] vin = 8'h00;
  logic [7:0] prev = 8'h00;
  logic       sdo, sdo_oe, hold, cmp;
  logic [7:0] dac;

  int n_run = 0, n_fail = 0;
  int run_len = 0, last_len = 0, n_conv = 0;
  logic [7:0] first_dac = 8'h00;
  logic hold_q = 1'b0;

  always #10 clk = ~clk;

  assign cmp = (vin >= dac);

  sadc_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ioclk_i(ioclk), .cmp_i(cmp),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .dac_code_o(dac), .hold_o(hold));

  always @(negedge clk) begin
    if (hold) begin
      if (!hold_q) first_dac <= dac;
      run_len <= run_len + 1;
    end else if (hold_q) begin
      last_len <= run_len;
      run_len  <= 0;
      n_conv   <= n_conv + 1;
    end
    hold_q <= hold;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic io_pulse();
    ioclk = 1'b1; tick(5);
    ioclk = 1'b0; tick(5);
  endtask

  // full access: checks MSB at select, every shift, ends on the 8th fall
  task automatic do_access(input logic [7:0] exp);
    cs_n = 1'b0; tick(6);
    check(sdo_oe === 1'b1, "R2 oe", int'(sdo_oe), 1);
    check(sdo === exp[7], "R2 msb", int'(sdo), int'(exp[7]));
    for (int i = 1; i < 8; i++) begin
      ioclk = 1'b1; tick(5);
      check(sdo === exp[8-i], "R3 rising edge", int'(sdo), int'(exp[8-i]));
      ioclk = 1'b0; tick(5);
      check(sdo === exp[7-i], "R3 shift", int'(sdo), int'(exp[7-i]));
    end
    ioclk = 1'b1; tick(5);
    ioclk = 1'b0;
  endtask

  task automatic t_reset();
    check(sdo_oe === 1'b0, "R1 reset oe", int'(sdo_oe), 0);
    check(hold === 1'b0, "R4 reset hold", int'(hold), 0);
    check(dac === 8'h00, "R6 reset dac", int'(dac), 0);
  endtask

  task automatic t_conv(input logic [7:0] v);
    int c0;
    c0  = n_conv;
    vin = v;
    do_access(prev);
    tick(60);
    check(n_conv == c0 + 1, "R4 one conversion", n_conv, c0 + 1);
    check(last_len == 36, "R4 hold length", last_len, 36);
    check(first_dac == 8'h80, "R6 first trial", int'(first_dac), 8'h80);
    cs_n = 1'b1; tick(6);
    check(sdo_oe === 1'b0, "R1 deselect", int'(sdo_oe), 0);
    prev = v;
  endtask

  task automatic t_abort();
    int c0;
    c0   = n_conv;
    cs_n = 1'b0; tick(6);
    check(sdo === prev[7], "R8 msb", int'(sdo), int'(prev[7]));
    repeat (3) io_pulse();
    cs_n = 1'b1; tick(60);
    check(n_conv == c0, "R8 no conversion", n_conv, c0);
    check(hold === 1'b0, "R8 hold idle", int'(hold), 0);
  endtask

  task automatic t_noise(input logic [7:0] v);
    int c0;
    c0  = n_conv;
    vin = v;
    do_access(prev);
    tick(8);
    check(hold === 1'b1, "R9 converting", int'(hold), 1);
    repeat (2) io_pulse();
    tick(40);
    check(last_len == 36, "R9 length kept", last_len, 36);
    check(n_conv == c0 + 1, "R9 single conversion", n_conv, c0 + 1);
    repeat (2) io_pulse();
    tick(60);
    check(n_conv == c0 + 1, "R10 extra edges", n_conv, c0 + 1);
    cs_n = 1'b1; tick(6);
    prev = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_conv(8'hA5);   // R5: first access returns 0x00
    t_conv(8'h3C);   // R5/R6: returns 0xA5
    t_abort();
    t_conv(8'h00);   // R8: reads 0x3C from MSB again
    t_conv(8'hFF);
    t_noise(8'h5A);
    t_conv(8'h01);   // R9: result 0x5A intact
    t_conv(8'h80);
    t_conv(8'h7E);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule